// File: doc/BRIEF.md
# Immediate-Operand Integer ALU

This block executes the group of 32-bit integer instructions that combine a destination operand with an immediate constant. The surrounding pipeline supplies the destination value already fetched, the 32-bit immediate, and either the addressing byte of a long-form instruction or the single opcode byte of a short accumulator form. One cycle later the block returns the result, a write-enable for the destination, and the new sign, zero and overflow flags. Operand fetch and the write-back itself belong to the caller.

In long form the operation is selected by a 3-bit code held in bits 5:3 of the addressing byte. The other bits of that byte select the destination and play no part here. In short form the opcode byte alone names the operation, and the destination is implicitly the accumulator. Compare produces flags without writing anything. Any code outside the supported set raises an illegal-instruction indication instead of a result.

Top module: `imm_alu`

## Requirements
- R1: In long form (shortForm=1'b0), modByte[5:3] selects the operation: 0 add, 1 or, 4 and, 5 subtract, 6 xor, 7 compare. Bits 7:6 and 2:0 of modByte have no effect on any output.
- R2: In short form (shortForm=1'b1), opcode 8'h2D subtracts, 8'h25 ands, 8'h0D ors, 8'h35 xors and 8'h3D compares, and modByte has no effect. Every other opcode value, 8'h05 included, is illegal.
- R3: Add and subtract produce the 32-bit wrapped result of dstIn+immIn or dstIn-immIn with wrEn=1. signFlag is result bit 31, zeroFlag is set when the result is zero, and ovfFlag is set when the signed result differs from the exact signed value.
- R4: And, or and xor produce the bitwise result with wrEn=1. signFlag and zeroFlag follow the result, and ovfFlag is cleared.
- R5: Compare forms dstIn-immIn and updates all three flags as subtract does. It presents the difference on result and keeps wrEn=0.
- R6: Long-form codes 2 and 3, and unlisted short opcodes, give illegal=1, wrEn=0 and result=0, and leave all three flags unchanged.
- R7: outValid is high for exactly the one cycle after each cycle with inValid high. wrEn and illegal are high only while outValid is high.
- R8: In a cycle with inValid low, the three flags keep their values.
- R9: After reset, outValid, wrEn, illegal and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An instruction is presented this cycle |
| shortForm | input | 1 | 1: accumulator short form decoded from opcode; 0: long form decoded from modByte |
| opcode | input | 8 | Opcode byte, used in short form |
| modByte | input | 8 | Addressing byte; bits 5:3 hold the operation code in long form |
| dstIn | input | 32 | Destination operand value |
| immIn | input | 32 | Immediate operand |
| outValid | output | 1 | Result and indications are valid |
| result | output | 32 | Computed value (difference for compare, 0 for illegal) |
| wrEn | output | 1 | Destination must be written with result |
| illegal | output | 1 | Unrecognised operation code |
| signFlag | output | 1 | Sign flag |
| zeroFlag | output | 1 | Zero flag |
| ovfFlag | output | 1 | Signed overflow flag |

## Verification
Assertions check these rules on every cycle. The one-cycle valid timing holds. No write occurs on an illegal code. Flags hold across idle cycles and illegal codes. Zero and sign flags agree with the presented result whenever it is legal. The assertions cannot see which operation ran, so the bench's scenarios must show the rest. These are the actual decoding of every long and short code, the ignored addressing bits, the signed overflow boundaries of add, subtract and compare, the cleared overflow of the logic ops, and the suppressed write of compare.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;

  // Position of the operation code inside the addressing byte
  localparam int SUBOP_LO = 3;
  localparam int SUBOP_W  = 3;
  localparam int SUBOP_HI = SUBOP_LO + SUBOP_W - 1;

  // Long-form operation codes
  localparam logic [SUBOP_W-1:0] CODE_ADD = 3'd0;
  localparam logic [SUBOP_W-1:0] CODE_OR  = 3'd1;
  localparam logic [SUBOP_W-1:0] CODE_AND = 3'd4;
  localparam logic [SUBOP_W-1:0] CODE_SUB = 3'd5;
  localparam logic [SUBOP_W-1:0] CODE_XOR = 3'd6;
  localparam logic [SUBOP_W-1:0] CODE_CMP = 3'd7;

  // Short accumulator forms
  localparam logic [7:0] SHORT_SUB = 8'h2D;
  localparam logic [7:0] SHORT_AND = 8'h25;
  localparam logic [7:0] SHORT_OR  = 8'h0D;
  localparam logic [7:0] SHORT_XOR = 8'h35;
  localparam logic [7:0] SHORT_CMP = 8'h3D;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_SUB,
    OP_AND,
    OP_OR,
    OP_XOR,
    OP_CMP
  } aluOpE;

  // Strobes from control to datapath
  typedef struct packed {
    logic  fire;
    aluOpE op;
    logic  writeBack;
    logic  flagLoad;
    logic  badCode;
  } aluStrobeT;

endpackage

// File: rtl/imm_alu_ctrl.sv
module imm_alu_ctrl
  import imm_alu_pkg::*;
(
  input  logic       inValid,
  input  logic       shortForm,
  input  logic [7:0] opcode,
  input  logic [7:0] modByte,
  output aluStrobeT  strobe
);

  logic [SUBOP_W-1:0] subCode;
  logic               unusedModBits;
  aluOpE              opSel;
  logic               bad;

  assign subCode       = modByte[SUBOP_HI:SUBOP_LO];
  assign unusedModBits = ^{modByte[7:SUBOP_HI+1], modByte[SUBOP_LO-1:0]};

  always_comb begin
    opSel = OP_ADD;
    bad   = 1'b0;
    if (shortForm) begin
      case (opcode)
        SHORT_SUB: opSel = OP_SUB;
        SHORT_AND: opSel = OP_AND;
        SHORT_OR:  opSel = OP_OR;
        SHORT_XOR: opSel = OP_XOR;
        SHORT_CMP: opSel = OP_CMP;
        default:   bad   = 1'b1;
      endcase
    end else begin
      case (subCode)
        CODE_ADD: opSel = OP_ADD;
        CODE_OR:  opSel = OP_OR;
        CODE_AND: opSel = OP_AND;
        CODE_SUB: opSel = OP_SUB;
        CODE_XOR: opSel = OP_XOR;
        CODE_CMP: opSel = OP_CMP;
        default:  bad   = 1'b1;
      endcase
    end
  end

  always_comb begin
    strobe.fire      = inValid;
    strobe.op        = opSel;
    strobe.badCode   = bad;
    strobe.flagLoad  = !bad;
    strobe.writeBack = !bad && (opSel != OP_CMP);
  end

endmodule

// File: rtl/imm_alu_dp.sv
module imm_alu_dp
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  aluStrobeT         strobe,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [DATA_W-1:0] immIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic              illegal,
  output logic              signFlag,
  output logic              zeroFlag,
  output logic              ovfFlag
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   sumWide;
  logic [DATA_W:0]   difWide;
  logic [DATA_W-1:0] nextRes;
  logic              nextOvf;

  // Sign-extended by one bit so the top two bits expose signed overflow
  assign sumWide = {dstIn[MSB], dstIn} + {immIn[MSB], immIn};
  assign difWide = {dstIn[MSB], dstIn} - {immIn[MSB], immIn};

  always_comb begin
    nextRes = '0;
    nextOvf = 1'b0;
    case (strobe.op)
      OP_ADD: begin
        nextRes = sumWide[MSB:0];
        nextOvf = sumWide[DATA_W] ^ sumWide[MSB];
      end
      OP_SUB, OP_CMP: begin
        nextRes = difWide[MSB:0];
        nextOvf = difWide[DATA_W] ^ difWide[MSB];
      end
      OP_AND:  nextRes = dstIn & immIn;
      OP_OR:   nextRes = dstIn | immIn;
      OP_XOR:  nextRes = dstIn ^ immIn;
      default: nextRes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      wrEn     <= 1'b0;
      illegal  <= 1'b0;
      result   <= '0;
      signFlag <= 1'b0;
      zeroFlag <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      outValid <= strobe.fire;
      wrEn     <= strobe.fire && strobe.writeBack;
      illegal  <= strobe.fire && strobe.badCode;
      if (strobe.fire) begin
        result <= strobe.badCode ? '0 : nextRes;
      end
      if (strobe.fire && strobe.flagLoad) begin
        signFlag <= nextRes[MSB];
        zeroFlag <= (nextRes == '0);
        ovfFlag  <= nextOvf;
      end
    end
  end

endmodule

// File: rtl/imm_alu.sv
module imm_alu
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              shortForm,
  input  logic [7:0]        opcode,
  input  logic [7:0]        modByte,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [DATA_W-1:0] immIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic              illegal,
  output logic              signFlag,
  output logic              zeroFlag,
  output logic              ovfFlag
);

  aluStrobeT strobe;

  imm_alu_ctrl u_ctrl (
    .inValid   (inValid),
    .shortForm (shortForm),
    .opcode    (opcode),
    .modByte   (modByte),
    .strobe    (strobe)
  );

  imm_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .dstIn    (dstIn),
    .immIn    (immIn),
    .outValid (outValid),
    .result   (result),
    .wrEn     (wrEn),
    .illegal  (illegal),
    .signFlag (signFlag),
    .zeroFlag (zeroFlag),
    .ovfFlag  (ovfFlag)
  );

endmodule

// File: rtl/imm_alu_chk.sv
module imm_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              wrEn,
  input logic              illegal,
  input logic              signFlag,
  input logic              zeroFlag,
  input logic              ovfFlag
);

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  assert_strobes_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn || illegal) |-> outValid);

  assert_illegal_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wrEn && result == '0));

  assert_illegal_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable({signFlag, zeroFlag, ovfFlag}));

  assert_idle_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> $stable({signFlag, zeroFlag, ovfFlag}));

  assert_zero_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !illegal) |-> (zeroFlag == (result == '0)));

  assert_sign_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !illegal) |-> (signFlag == result[DATA_W-1]));

endmodule

bind imm_alu imm_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .outValid (outValid),
  .result   (result),
  .wrEn     (wrEn),
  .illegal  (illegal),
  .signFlag (signFlag),
  .zeroFlag (zeroFlag),
  .ovfFlag  (ovfFlag)
);

// File: tb/imm_alu_test.sv
module imm_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        shortForm = 1'b0;
  logic [7:0]  opcode = '0;
  logic [7:0]  modByte = '0;
  logic [31:0] dstIn = '0;
  logic [31:0] immIn = '0;
  logic        outValid, wrEn, illegal, signFlag, zeroFlag, ovfFlag;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Expected outputs for the next sampled cycle
  bit          eValid = 0, eWr = 0, eIll = 0, eSf = 0, eZf = 0, eOf = 0;
  logic [31:0] eRes = '0;
  string       eTag = "R9";

  always #2 clk = ~clk;

  imm_alu uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .shortForm(shortForm),
    .opcode(opcode), .modByte(modByte), .dstIn(dstIn), .immIn(immIn),
    .outValid(outValid), .result(result), .wrEn(wrEn), .illegal(illegal),
    .signFlag(signFlag), .zeroFlag(zeroFlag), .ovfFlag(ovfFlag)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: kind 0 add,1 sub,2 and,3 or,4 xor,5 cmp,6 illegal
  task automatic model(bit v, bit sh, logic [7:0] op, logic [7:0] mb,
                       logic [31:0] d, logic [31:0] i, string tagOvr);
    int kind;
    longint wide;
    logic [31:0] r;
    eValid = v;
    if (!v) begin
      eWr = 0; eIll = 0; eTag = "R8";
      return;
    end
    if (sh) begin
      if (op == 8'h2D) kind = 1;
      else if (op == 8'h25) kind = 2;
      else if (op == 8'h0D) kind = 3;
      else if (op == 8'h35) kind = 4;
      else if (op == 8'h3D) kind = 5;
      else kind = 6;
    end else begin
      case (int'(mb[5:3]))
        0: kind = 0;
        1: kind = 3;
        4: kind = 2;
        5: kind = 1;
        6: kind = 4;
        7: kind = 5;
        default: kind = 6;
      endcase
    end
    if (kind == 6) begin
      eWr = 0; eIll = 1; eRes = '0; eTag = "R6";
    end else begin
      eIll = 0;
      eWr = (kind != 5);
      if (kind == 0) wide = longint'($signed(d)) + longint'($signed(i));
      else if (kind == 1 || kind == 5) wide = longint'($signed(d)) - longint'($signed(i));
      else wide = 0;
      case (kind)
        2: r = d & i;
        3: r = d | i;
        4: r = d ^ i;
        default: r = wide[31:0];
      endcase
      eRes = r;
      eSf = r[31];
      eZf = (r == 32'd0);
      eOf = (kind == 0 || kind == 1 || kind == 5) ?
            (longint'($signed(r)) != wide) : 1'b0;
      eTag = (kind == 5) ? "R5" : ((kind == 0 || kind == 1) ? "R3" : "R4");
    end
    if (tagOvr != "") eTag = tagOvr;
  endtask

  task automatic step(bit v, bit sh, logic [7:0] op, logic [7:0] mb,
                      logic [31:0] d, logic [31:0] i, string tagOvr);
    @(negedge clk);
    chk("R7", "outValid", {31'd0, outValid}, {31'd0, eValid});
    chk(eValid ? eTag : "R7", "wrEn", {31'd0, wrEn}, {31'd0, eWr});
    chk(eValid ? eTag : "R7", "illegal", {31'd0, illegal}, {31'd0, eIll});
    if (eValid) chk(eTag, "result", result, eRes);
    chk(eTag, "flags", {29'd0, signFlag, zeroFlag, ovfFlag}, {29'd0, eSf, eZf, eOf});
    inValid = v; shortForm = sh; opcode = op; modByte = mb; dstIn = d; immIn = i;
    model(v, sh, op, mb, d, i, tagOvr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R7 watchdog actual=expired expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: first step checks the reset state (eTag starts as R9)
    step(0, 0, 8'h00, 8'h00, 32'h0, 32'h0, "R9");
    // R3 add overflow positive, wrap to zero
    step(1, 0, 8'h81, 8'hC2, 32'h7FFF_FFFF, 32'h0000_0001, "R3");
    step(1, 0, 8'h81, 8'h05, 32'hFFFF_FFFF, 32'h0000_0001, "R3");
    // R3 subtract overflow, short and long
    step(1, 1, 8'h2D, 8'hFF, 32'h8000_0000, 32'h0000_0001, "R3");
    step(1, 0, 8'h81, 8'h2B, 32'h0000_0030, 32'h0000_0031, "R3");
    // R4 logic ops clear overflow
    step(1, 0, 8'h81, 8'h23, 32'hF0F0_1234, 32'h0F0F_FFFF, "R4");
    step(1, 1, 8'h0D, 8'h00, 32'h8100_0000, 32'h0000_00A5, "R4");
    step(1, 1, 8'h35, 8'h12, 32'h5A5A_5A5A, 32'h5A5A_5A5A, "R4");
    // R5 compare: equal, lesser, overflow, no write
    step(1, 1, 8'h3D, 8'h00, 32'h1357_9BDF, 32'h1357_9BDF, "R5");
    step(1, 0, 8'h81, 8'hF9, 32'h0000_0004, 32'h0000_0009, "R5");
    step(1, 0, 8'h81, 8'h38, 32'h7FFF_FFF0, 32'hFFFF_FF00, "R5");
    // R6 illegal long codes 2, 3 and short 0x05 / random opcode keep flags
    step(1, 0, 8'h81, 8'h10, 32'h0, 32'h0, "R6");
    step(1, 0, 8'h81, 8'hDF, 32'h1, 32'h1, "R6");
    step(1, 1, 8'h05, 8'h00, 32'h0, 32'h0, "R6");
    step(1, 1, 8'h81, 8'h28, 32'h5, 32'h5, "R6");
    // R8 idle cycles with busy inputs
    step(0, 0, 8'h81, 8'h00, 32'h0, 32'h0, "R8");
    step(0, 1, 8'h2D, 8'h00, 32'h1, 32'h1, "R8");
    // R1: same code with varying outer bits of the addressing byte
    step(1, 0, 8'h81, 8'h30, 32'hDEAD_0001, 32'h0000_FFFF, "R1");
    step(1, 0, 8'h81, 8'hF7, 32'hDEAD_0001, 32'h0000_FFFF, "R1");
    step(1, 0, 8'h81, 8'h08, 32'h0000_0F00, 32'h0000_00F0, "R1");
    // R2: short forms ignore modByte, including a byte that decodes as illegal
    step(1, 1, 8'h25, 8'h10, 32'hFFFF_00FF, 32'h0F0F_0F0F, "R2");
    step(1, 1, 8'h2D, 8'h18, 32'h0000_0000, 32'h0000_0001, "R2");
    // R7 back-to-back then idle
    step(1, 0, 8'h81, 8'h00, 32'h1, 32'h2, "R7");
    step(0, 0, 8'h00, 8'h00, 32'h0, 32'h0, "R7");
    // Mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] sop;
      int pick;
      pick = $urandom_range(0, 6);
      case (pick)
        0: sop = 8'h2D;
        1: sop = 8'h25;
        2: sop = 8'h0D;
        3: sop = 8'h35;
        4: sop = 8'h3D;
        5: sop = 8'h05;
        default: sop = 8'($urandom);
      endcase
      step(($urandom_range(0, 7) != 0), $urandom_range(0, 1) == 1, sop,
           8'($urandom), (n % 5 == 0) ? 32'h7FFF_FFFF : $urandom,
           (n % 7 == 0) ? 32'h8000_0000 : $urandom, "");
    end
    step(0, 0, 8'h00, 8'h00, 32'h0, 32'h0, "");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule